// File: doc/BRIEF.md
# Platform Interrupt Controller Register File

This block is the register file and arbitration core of a platform-level interrupt controller. It collects level-sensitive interrupt lines from a parameterized number of sources. Each source has a programmable priority. Each target context has its own enable mask and priority threshold. The block raises one interrupt line per context whenever that context has work waiting. Software reaches all of this state through a plain 32-bit register bus, which carries a byte address, separate read and write strobes, write data and combinational read data.

A context handler takes an interrupt by reading its claim register. That read returns the ID of the best candidate source. In the same access the source moves from pending to claimed, so no other context can take it. When service is done, the handler writes the same ID back to the claim register, and the source becomes eligible again. Priority and threshold values are legalized on write. When the level count plus one is a power of two, the value wraps modulo that count. Otherwise an oversized value is discarded and the register keeps its old content.

Top module: `pic_regfile`

## Requirements
- R1: Source n has a priority register at PRIO_BASE + 4*n for n in 0..NUM_SRC-1. A read returns the stored value in the low bits and zero above them.
- R2: Pending state reads as packed words at PEND_BASE + 4*w. Bit b of word w belongs to source 32*w+b. Bus writes to these words change nothing.
- R3: Context c has enable word w at EN_BASE + c*EN_STRIDE + 4*w. All 32 bits of the word read back as written. Word indexes of WORDS or above read 0 and ignore writes.
- R4: Each context owns a block of CTX_STRIDE bytes at CTX_BASE + c*CTX_STRIDE. Byte offset 0 of that block holds the threshold, and offset 4 holds claim/complete.
- R5: A claim read returns the ID of the source with the highest priority among those that are pending, enabled for the context, not claimed, and strictly above the context threshold. On equal priority the lower ID wins. The read returns 0 when no source qualifies.
- R6: A claim read that returns a nonzero ID clears that source's pending bit and sets its claimed bit on the same clock edge. A claim read that returns 0 changes no state.
- R7: Writing value v to claim/complete clears the claimed bit of source v when v < NUM_SRC. Any larger value has no effect.
- R8: If PRIO_LEVELS+1 is a power of two, priority and threshold writes store the value modulo PRIO_LEVELS+1. Otherwise a write above PRIO_LEVELS is dropped and the old value stays.
- R9: On every clock edge the pending bit of each source n >= 1 takes the level of src_in[n]. Source 0 is never pending.
- R10: irq_out[c] is high exactly when a claim read by context c would return a nonzero ID. The output reflects the registered state, so it changes one cycle after the access or input change that caused the change.
- R11: While rst_n is low, all priorities, thresholds, pending bits, claimed bits and enables are zero, and every irq_out bit is low.
- R12: rdata is 0 when rd_en is low, and also when a read hits an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Level interrupt lines; bit n belongs to source n |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a claim read takes effect at the clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en |
| irq_out | output | NUM_CTX | One interrupt request per context |

## Verification
The main bench instance uses 40 sources, two contexts and seven priority levels. With 40 sources the second pending and enable words are only partly populated. Seven levels makes the level count plus one a power of two, so writes wrap. The bench sweeps a single active source across every ID. For each ID it predicts the claim result, the interrupt level of both contexts and the pending clear by arithmetic over its own priority, enable and claim model. A second instance uses five levels, which reaches the drop-on-oversize branch of the legalizing rule. Directed sequences then cover an equal-priority pair, a threshold that masks every source, and a completion ID that is out of range but aliases a live source in its low bits.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Address region decoded for a register access.
    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_PRIO,
        RGN_PEND,
        RGN_EN,
        RGN_CTX
    } rgn_e;

    // True when a lies in [base, base + span).
    function automatic logic in_span(logic [31:0] a, logic [31:0] base, logic [31:0] span);
        return (a >= base) && ((a - base) < span);
    endfunction

endpackage

// File: rtl/pic_prio_legal.sv
module pic_prio_legal #(
    parameter int LEVELS = 7,
    parameter int PW     = 3
) (
    input  logic [31:0]   value,
    output logic [PW-1:0] legal,
    output logic          drop
);
    localparam bit WRAP = ((LEVELS + 1) & LEVELS) == 0;

    logic unused_hi;
    assign unused_hi = ^value[31:PW];

    generate
        if (WRAP) begin : g_wrap
            // Modulo a power of two keeps only the low bits.
            assign legal = (LEVELS == 0) ? '0 : value[PW-1:0];
            assign drop  = 1'b0;
        end else begin : g_clip
            assign legal = value[PW-1:0];
            assign drop  = (value > 32'(LEVELS));
        end
    endgenerate

endmodule

// File: rtl/pic_prio_sel.sv
module pic_prio_sel #(
    parameter int NUM_SRC = 40,
    parameter int PW      = 3,
    parameter int IDW     = 6
) (
    input  logic [NUM_SRC-1:0]         cand,
    input  logic [NUM_SRC-1:0][PW-1:0] prio,
    input  logic [PW-1:0]              thr,
    output logic [IDW-1:0]             id
);
    logic [PW-1:0] best;
    logic          unused_zero;

    assign unused_zero = cand[0] ^ (^prio[0]);

    // Strict compare: the first (lowest) ID keeps a tie.
    always_comb begin
        best = thr;
        id   = '0;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (cand[i] && (prio[i] > best)) begin
                best = prio[i];
                id   = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
    import pic_pkg::*;
#(
    parameter int          NUM_SRC     = 40,
    parameter int          NUM_CTX     = 2,
    parameter int          PRIO_LEVELS = 7,
    parameter int          ADDR_W      = 24,
    parameter logic [31:0] PRIO_BASE   = 32'h0000_0000,
    parameter logic [31:0] PEND_BASE   = 32'h0000_1000,
    parameter logic [31:0] EN_BASE     = 32'h0000_2000,
    parameter logic [31:0] EN_STRIDE   = 32'h0000_0080,
    parameter logic [31:0] CTX_BASE    = 32'h0020_0000,
    parameter logic [31:0] CTX_STRIDE  = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [NUM_CTX-1:0] irq_out
);
    localparam int WORDS  = (NUM_SRC + 31) / 32;
    localparam int PADW   = WORDS * 32;
    localparam int PW     = (PRIO_LEVELS < 1) ? 1 : $clog2(PRIO_LEVELS + 1);
    localparam int IDW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int WW     = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int CW     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
    localparam int EN_SH  = $clog2(EN_STRIDE);
    localparam int CTX_SH = $clog2(CTX_STRIDE);

    typedef struct packed {
        logic [NUM_SRC-1:0][PW-1:0] prio;
        logic [NUM_CTX-1:0][PW-1:0] thr;
        logic [NUM_SRC-1:0]         pend;
        logic [NUM_SRC-1:0]         clm;
        logic [NUM_CTX-1:0][PADW-1:0] en;
    } state_t;

    state_t state_q, state_d;

    // Per-context selection.
    logic [NUM_CTX-1:0][IDW-1:0] sel_id;

    generate
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            logic [NUM_SRC-1:0] cand;
            assign cand = state_q.pend & ~state_q.clm & state_q.en[c][NUM_SRC-1:0];
            pic_prio_sel #(
                .NUM_SRC(NUM_SRC),
                .PW     (PW),
                .IDW    (IDW)
            ) u_sel (
                .cand(cand),
                .prio(state_q.prio),
                .thr (state_q.thr[c]),
                .id  (sel_id[c])
            );
            assign irq_out[c] = (sel_id[c] != '0);
        end
    endgenerate

    // One legalizer serves both priority and threshold writes.
    logic [PW-1:0] legal_val;
    logic          legal_drop;

    pic_prio_legal #(
        .LEVELS(PRIO_LEVELS),
        .PW    (PW)
    ) u_legal (
        .value(wdata),
        .legal(legal_val),
        .drop (legal_drop)
    );

    // Decode and next-state logic.
    logic [31:0]     a32, rel_p, rel_n, rel_e, rel_c, eword, coff;
    logic [IDW-1:0]  pidx;
    logic [WW-1:0]   widx, ewidx;
    logic [CW-1:0]   ectx, cctx;
    logic [PADW-1:0] pend_pad;
    rgn_e            rgn;
    logic            claim_take, cmpl_ok;
    logic [IDW-1:0]  take_id, cmpl_id;

    always_comb begin
        a32      = 32'(addr);
        rel_p    = a32 - PRIO_BASE;
        rel_n    = a32 - PEND_BASE;
        rel_e    = a32 - EN_BASE;
        rel_c    = a32 - CTX_BASE;
        pidx     = IDW'(rel_p >> 2);
        widx     = WW'(rel_n >> 2);
        ectx     = CW'(rel_e >> EN_SH);
        eword    = (rel_e & (EN_STRIDE - 32'd1)) >> 2;
        ewidx    = WW'(eword);
        cctx     = CW'(rel_c >> CTX_SH);
        coff     = rel_c & (CTX_STRIDE - 32'd1);
        pend_pad = PADW'(state_q.pend);

        if (in_span(a32, PRIO_BASE, 32'(NUM_SRC * 4)))                rgn = RGN_PRIO;
        else if (in_span(a32, PEND_BASE, 32'(WORDS * 4)))             rgn = RGN_PEND;
        else if (in_span(a32, EN_BASE, 32'(NUM_CTX) * EN_STRIDE))     rgn = RGN_EN;
        else if (in_span(a32, CTX_BASE, 32'(NUM_CTX) * CTX_STRIDE))   rgn = RGN_CTX;
        else                                                          rgn = RGN_NONE;

        state_d    = state_q;
        rdata      = '0;
        claim_take = 1'b0;
        take_id    = '0;
        cmpl_ok    = 1'b0;
        cmpl_id    = '0;

        // Pending tracks the source levels; source 0 is reserved.
        state_d.pend    = src_in;
        state_d.pend[0] = 1'b0;

        unique case (rgn)
            RGN_PRIO: begin
                if (rd_en) rdata = 32'(state_q.prio[pidx]);
                if (wr_en && !legal_drop) state_d.prio[pidx] = legal_val;
            end
            RGN_PEND: begin
                if (rd_en) rdata = pend_pad[widx*32 +: 32];
            end
            RGN_EN: begin
                if (eword < 32'(WORDS)) begin
                    if (rd_en) rdata = state_q.en[ectx][ewidx*32 +: 32];
                    if (wr_en) state_d.en[ectx][ewidx*32 +: 32] = wdata;
                end
            end
            RGN_CTX: begin
                if (coff == 32'd0) begin
                    if (rd_en) rdata = 32'(state_q.thr[cctx]);
                    if (wr_en && !legal_drop) state_d.thr[cctx] = legal_val;
                end else if (coff == 32'd4) begin
                    if (rd_en) begin
                        rdata = 32'(sel_id[cctx]);
                        if (sel_id[cctx] != '0) begin
                            claim_take             = 1'b1;
                            take_id                = sel_id[cctx];
                            state_d.pend[take_id]  = 1'b0;
                            state_d.clm[take_id]   = 1'b1;
                        end
                    end
                    if (wr_en && (wdata < 32'(NUM_SRC))) begin
                        cmpl_ok              = 1'b1;
                        cmpl_id              = IDW'(wdata);
                        state_d.clm[cmpl_id] = 1'b0;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/pic_regfile_chk.sv
module pic_regfile_chk #(
    parameter int NUM_SRC     = 40,
    parameter int NUM_CTX     = 2,
    parameter int PW          = 3,
    parameter int IDW         = 6,
    parameter int PRIO_LEVELS = 7
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_SRC-1:0]           src_in,
    input logic [NUM_CTX-1:0]           irq_out,
    input logic [NUM_SRC-1:0]           pend_q,
    input logic [NUM_SRC-1:0]           clm_q,
    input logic [NUM_SRC-1:0][PW-1:0]   prio_q,
    input logic                         take,
    input logic [IDW-1:0]               take_id,
    input logic                         cmpl,
    input logic [IDW-1:0]               cmpl_id
);
    // R11: no request while held in reset.
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (irq_out == '0));

    // R6: a nonzero claim marks the source claimed.
    a_r6_claim_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cmpl) |=> clm_q[$past(take_id)]);

    // R7: an in-range completion releases the source.
    a_r7_complete_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl && !take) |=> !clm_q[$past(cmpl_id)]);

    // R9: a pending bit is only ever set for a line that was high.
    a_r9_pending_from_level: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(src_in)) == '0));

    // R9: source 0 is never pending.
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]);

    // R10: a request needs some pending, unclaimed source.
    a_r10_irq_has_work: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> ((pend_q & ~clm_q) != '0));

    // R8: stored priorities stay within the level count.
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_p
            a_r8_prio_legal: assert property (@(posedge clk) disable iff (!rst_n)
                32'(prio_q[i]) <= 32'(PRIO_LEVELS));
        end
    endgenerate

endmodule

bind pic_regfile pic_regfile_chk #(
    .NUM_SRC    (NUM_SRC),
    .NUM_CTX    (NUM_CTX),
    .PW         (PW),
    .IDW        (IDW),
    .PRIO_LEVELS(PRIO_LEVELS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_in (src_in),
    .irq_out(irq_out),
    .pend_q (state_q.pend),
    .clm_q  (state_q.clm),
    .prio_q (state_q.prio),
    .take   (claim_take),
    .take_id(take_id),
    .cmpl   (cmpl_ok),
    .cmpl_id(cmpl_id)
);

// File: tb/tb_pic_regfile.sv
module tb_pic_regfile;
    localparam int          NS = 40;
    localparam logic [31:0] PB = 32'h0000_0000;
    localparam logic [31:0] NB = 32'h0000_1000;
    localparam logic [31:0] EB = 32'h0000_2000;
    localparam logic [31:0] ES = 32'h0000_0080;
    localparam logic [31:0] CB = 32'h0020_0000;
    localparam logic [31:0] CS = 32'h0000_1000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic [NS-1:0] src;
    logic [23:0]   addr;
    logic [31:0]   wdata, rdata_a, rdata_b;
    logic          wr_a, rd_a, wr_b, rd_b;
    logic [1:0]    irq_a, irq_b;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    int            mprio[NS];
    int            mthr0, mthr1;
    logic [NS-1:0] men0, men1, mclm;

    pic_regfile dut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .addr(addr),
        .wr_en(wr_a), .rd_en(rd_a), .wdata(wdata), .rdata(rdata_a), .irq_out(irq_a)
    );

    pic_regfile #(.PRIO_LEVELS(5)) dut_b (
        .clk(clk), .rst_n(rst_n), .src_in({NS{1'b0}}), .addr(addr),
        .wr_en(wr_b), .rd_en(rd_b), .wdata(wdata), .rdata(rdata_b), .irq_out(irq_b)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got=%0d cycles exp=<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input bit b, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a[23:0];
        wdata = d;
        if (b) wr_b = 1'b1; else wr_a = 1'b1;
        @(posedge clk);
        #1;
        wr_a = 1'b0;
        wr_b = 1'b0;
    endtask

    task automatic rd(input bit b, input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a[23:0];
        if (b) rd_b = 1'b1; else rd_a = 1'b1;
        #1;
        d = b ? rdata_b : rdata_a;
        @(posedge clk);
        #1;
        rd_a = 1'b0;
        rd_b = 1'b0;
    endtask

    task automatic setsrc(input logic [NS-1:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
        #1;
    endtask

    task automatic rdchk(input bit b, input logic [31:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(b, a, d);
        chk(tag, d, exp);
    endtask

    function automatic int exp_id(input logic [NS-1:0] en, input int thr);
        int best = thr;
        int id = 0;
        for (int i = 1; i < NS; i++) begin
            if (src[i] && en[i] && !mclm[i] && (mprio[i] > best)) begin
                best = mprio[i];
                id   = i;
            end
        end
        return id;
    endfunction

    task automatic claim(input int ctx, input string tag, output int got);
        logic [31:0] d;
        int e;
        e = (ctx == 0) ? exp_id(men0, mthr0) : exp_id(men1, mthr1);
        rd(1'b0, CB + 32'(ctx) * CS + 32'd4, d);
        chk(tag, d, 32'(e));
        if (e != 0) mclm[e] = 1'b1;
        got = e;
    endtask

    task automatic complete(input int ctx, input logic [31:0] id);
        wr(1'b0, CB + 32'(ctx) * CS + 32'd4, id);
        if (id < 32'(NS)) mclm[id] = 1'b0;
    endtask

    initial begin
        int got;
        logic [31:0] d;
        int last;

        rst_n = 1'b0;
        src   = '0;
        addr  = '0;
        wdata = '0;
        wr_a  = 1'b0; rd_a = 1'b0; wr_b = 1'b0; rd_b = 1'b0;
        mthr0 = 0; mthr1 = 0; men0 = '0; men1 = '0; mclm = '0;
        for (int i = 0; i < NS; i++) mprio[i] = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 irq in reset", 32'(irq_a), 32'd0);
        rst_n = 1'b1;

        // R11: every register reads zero after reset.
        for (int i = 0; i < NS; i++) rdchk(1'b0, PB + 32'(4 * i), 32'd0, "R11 prio");
        for (int w = 0; w < 2; w++) rdchk(1'b0, NB + 32'(4 * w), 32'd0, "R11 pend");
        for (int c = 0; c < 2; c++)
            for (int w = 0; w < 2; w++) rdchk(1'b0, EB + 32'(c) * ES + 32'(4 * w), 32'd0, "R11 en");
        rdchk(1'b0, CB, 32'd0, "R11 thr0");
        rdchk(1'b0, CB + CS, 32'd0, "R11 thr1");

        // R1: sweep priority writes and readback.
        for (int i = 0; i < NS; i++) begin
            mprio[i] = (i * 3) % 8;
            wr(1'b0, PB + 32'(4 * i), 32'(mprio[i]));
        end
        for (int i = 0; i < NS; i++) rdchk(1'b0, PB + 32'(4 * i), 32'(mprio[i]), "R1 prio");

        // R8: wrapping variant (7 levels).
        wr(1'b0, PB + 32'(4 * 39), 32'd14);
        mprio[39] = 14 % 8;
        rdchk(1'b0, PB + 32'(4 * 39), 32'd6, "R8 wrap prio");
        wr(1'b0, CB + CS, 32'd9);
        rdchk(1'b0, CB + CS, 32'd1, "R8 wrap thr");
        wr(1'b0, CB + CS, 32'd0);
        // R4: threshold of context 0 at offset 0.
        wr(1'b0, CB, 32'd3);
        rdchk(1'b0, CB, 32'd3, "R4 thr0");
        wr(1'b0, CB, 32'd0);

        // R8: dropping variant (5 levels).
        last = 0;
        for (int v = 0; v < 10; v++) begin
            wr(1'b1, PB + 32'd12, 32'(v));
            if (v <= 5) last = v;
            rdchk(1'b1, PB + 32'd12, 32'(last), "R8 drop prio");
        end
        wr(1'b1, CB, 32'd3);
        wr(1'b1, CB, 32'd6);
        rdchk(1'b1, CB, 32'd3, "R8 drop thr");

        // R3: enable words.
        men0 = '1;
        men1 = {8'h55, 32'h0000_AAAA};
        wr(1'b0, EB, 32'hFFFF_FFFF);
        wr(1'b0, EB + 32'd4, 32'hFFFF_FFFF);
        wr(1'b0, EB + ES, 32'h0000_AAAA);
        wr(1'b0, EB + ES + 32'd4, 32'h0000_0055);
        rdchk(1'b0, EB, 32'hFFFF_FFFF, "R3 en0w0");
        rdchk(1'b0, EB + 32'd4, 32'hFFFF_FFFF, "R3 en0w1");
        rdchk(1'b0, EB + ES, 32'h0000_AAAA, "R3 en1w0");
        rdchk(1'b0, EB + ES + 32'd4, 32'h0000_0055, "R3 en1w1");
        wr(1'b0, EB + 32'd8, 32'h0000_1234);
        rdchk(1'b0, EB + 32'd8, 32'd0, "R3 beyond words");
        rdchk(1'b0, EB, 32'hFFFF_FFFF, "R3 word0 intact");

        // R2, R9: pending follows levels; source 0 ignored; writes ignored.
        setsrc(40'hA5_1234_5679);
        rdchk(1'b0, NB, 32'h1234_5678, "R2 pend w0");
        rdchk(1'b0, NB + 32'd4, 32'h0000_00A5, "R2 pend w1");
        wr(1'b0, NB, 32'd0);
        rdchk(1'b0, NB, 32'h1234_5678, "R2 pend write ignored");
        setsrc('0);
        rdchk(1'b0, NB, 32'd0, "R9 pend low");

        // R5, R6, R10: single-source sweep over every ID.
        for (int i = 1; i < NS; i++) begin
            setsrc(NS'(1) << i);
            chk("R10 irq ctx0", 32'(irq_a[0]), 32'(mprio[i] > mthr0));
            chk("R10 irq ctx1", 32'(irq_a[1]), 32'(men1[i] && (mprio[i] > mthr1)));
            claim(0, "R5 sweep claim", got);
            if (got != 0) begin
                rd(1'b0, NB + 32'(4 * (i / 32)), d);
                chk("R6 pend cleared", 32'(d[i % 32]), 32'd0);
                @(negedge clk);
                #1;
                chk("R6 irq after claim", 32'(irq_a[0]), 32'd0);
                complete(0, 32'(got));
            end
            setsrc('0);
        end

        // R5: equal-priority pair, lower ID first.
        wr(1'b0, PB + 32'd40, 32'd6);  mprio[10] = 6;
        wr(1'b0, PB + 32'd80, 32'd6);  mprio[20] = 6;
        setsrc((NS'(1) << 10) | (NS'(1) << 20));
        claim(0, "R5 pair first", got);
        chk("R5 pair first id", 32'(got), 32'd10);
        claim(0, "R5 pair second", got);
        chk("R5 pair second id", 32'(got), 32'd20);
        claim(0, "R5 pair none", got);
        @(negedge clk);
        #1;
        chk("R10 irq none left", 32'(irq_a[0]), 32'd0);
        claim(1, "R5 ctx1 masked", got);
        complete(0, 32'd10);
        claim(0, "R7 reclaim", got);
        chk("R7 reclaim id", 32'(got), 32'd10);
        complete(0, 32'd10);
        complete(0, 32'd20);

        // R5, R6: threshold masking every source.
        wr(1'b0, PB + 32'd156, 32'd6); mprio[39] = 6;
        setsrc((NS'(1) << 10) | (NS'(1) << 20) | (NS'(1) << 39));
        wr(1'b0, CB, 32'd7); mthr0 = 7;
        @(negedge clk);
        #1;
        chk("R10 irq masked", 32'(irq_a[0]), 32'd0);
        claim(0, "R5 thr masks", got);
        rdchk(1'b0, NB, 32'h0010_0400, "R6 zero claim keeps pend");
        wr(1'b0, CB, 32'd5); mthr0 = 5;
        claim(0, "R5 thr lowered", got);

        // R7: out-of-range completion, including an alias of ID 10.
        complete(0, 32'd74);
        complete(0, 32'd40);
        claim(0, "R7 out of range ignored", got);
        chk("R7 next id", 32'(got), 32'd20);
        complete(0, 32'd10);
        complete(0, 32'd20);
        claim(0, "R7 after complete", got);
        chk("R7 id10 back", 32'(got), 32'd10);
        complete(0, 32'd10);

        // R12: unmapped offsets and idle read strobe.
        rdchk(1'b0, 32'h0000_1800, 32'd0, "R12 unmapped");
        rdchk(1'b0, CB + 32'd8, 32'd0, "R12 ctx hole");
        @(negedge clk);
        addr = 24'h000004;
        #1;
        chk("R12 no rd_en", rdata_a, 32'd0);

        // R11: reset mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R11 irq cleared", 32'(irq_a), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        src   = '0;
        rdchk(1'b0, PB + 32'd40, 32'd0, "R11 prio cleared");
        rdchk(1'b0, EB, 32'd0, "R11 en cleared");
        rdchk(1'b0, CB, 32'd0, "R11 thr cleared");

        summary();
        $finish;
    end

endmodule